// File: doc/BRIEF.md
# Ping-Pong Receive Packet Buffer for a Bulk OUT Endpoint

This block holds the data of a bulk OUT endpoint while it waits to be read. It has two banks, and each bank holds one maximum-size packet, so the default storage is 2 x 64 bytes. The bus side delivers bytes with a valid strobe and ends each packet with a good marker or a bad marker. A good packet seals the bank it was written into. A bad packet throws away what it wrote. Packet decoding, CRC checking and handshakes are done upstream.

The CPU or a DMA engine takes the bytes from the readable bank one strobe at a time. It can see the sealed byte count of that bank, and a DMA request stays high while unread bytes remain. A one-cycle release pulse hands the bank back to the bus side. The other bank, if it is sealed, then becomes readable, so packets come out in arrival order. When both banks are sealed the endpoint reports busy, and further bus traffic is dropped. A synchronous clear empties everything.

Top module: `usb_rx_pingpong`

## Requirements
- R1: Bytes of every good packet come out of `rd_data` in the order they were written, and packets come out in the order they arrived.
- R2: `rx_size` shows the byte count of the readable bank while that bank holds a sealed packet, and 0 otherwise. Bytes beyond PKT_BYTES in one packet are dropped, so the count stops at PKT_BYTES.
- R3: While a bank is readable, its count and contents stay unchanged until it is released. A packet that ends meanwhile is stored in the other bank.
- R4: A `rd_done` pulse while a bank is readable frees that bank and returns the read pointer to 0. The other bank then becomes readable if it is sealed. A `rd_done` pulse with no readable bank has no effect.
- R5: `dma_req` is 1 exactly when the readable bank still holds unread bytes.
- R6: `nak_busy` is 1 while both banks hold sealed packets. Bytes and good markers that arrive during that time are ignored.
- R7: A `clr` pulse empties both banks. After it, `rx_size`=0, `dma_req`=0, `nak_busy`=0 and `underflow`=0, and pointers restart at 0.
- R8: A read strobe with no unread byte available returns 0 on `rd_data` and sets `underflow`. The flag stays set until `clr` or reset.
- R9: A `pkt_bad` marker discards the bytes of the packet being written. The write count returns to 0, and the bank stays free.
- R10: `rd_data` is registered. It shows the byte for a read strobe in the cycle after that strobe, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of both banks |
| wr_valid | input | 1 | Byte strobe from the bus side |
| wr_data | input | DATA_W | Received byte |
| pkt_good | input | 1 | End of a packet that passed checks (a byte in the same cycle belongs to it) |
| pkt_bad | input | 1 | End of a packet that failed checks |
| rd_strobe | input | 1 | Read one byte from the readable bank |
| rd_done | input | 1 | Release the readable bank |
| rd_data | output | DATA_W | Registered read byte |
| rx_size | output | CNT_W | Byte count of the readable bank |
| dma_req | output | 1 | Unread bytes are available |
| nak_busy | output | 1 | Both banks are sealed |
| underflow | output | 1 | Sticky flag for reading an empty bank |

## Verification
The checker assumes that `pkt_good` and `pkt_bad` never arrive in the same cycle. It also assumes that `rd_done` and `clr` are single-cycle pulses. The bench drives markers only as one-cycle pulses that follow the data bytes, and never raises both markers at once. Reads are issued one strobe per cycle, and the bench releases a bank only after it has decided how much of that bank to drain. This lets the scoreboard queue predict every byte in order.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
    localparam int NUM_BANKS = 2;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;

    function automatic bank_e other_bank(input bank_e b);
        return (b == BANK_A) ? BANK_B : BANK_A;
    endfunction
endpackage

// File: rtl/rxb_bank_mem.sv
module rxb_bank_mem #(
    parameter int DATA_W    = 8,
    parameter int PKT_BYTES = 64,
    localparam int ADDR_W   = $clog2(PKT_BYTES)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              wbank,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rbank,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] bank_rd [rxb_pkg::NUM_BANKS];

    for (genvar b = 0; b < rxb_pkg::NUM_BANKS; b++) begin : g_bank
        logic [DATA_W-1:0] store [PKT_BYTES];

        always_ff @(posedge clk) begin
            if (we && (wbank == b[0])) begin
                store[waddr] <= wdata;
            end
        end

        assign bank_rd[b] = store[raddr];
    end

    assign rdata = bank_rd[rbank];
endmodule

// File: rtl/rxb_ctrl.sv
module rxb_ctrl
    import rxb_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int PKT_BYTES = 64,
    localparam int ADDR_W   = $clog2(PKT_BYTES),
    localparam int CNT_W    = $clog2(PKT_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_valid,
    input  logic              pkt_good,
    input  logic              pkt_bad,
    input  logic              rd_strobe,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic              mem_wbank,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic              mem_rbank,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  rx_size,
    output logic              dma_req,
    output logic              nak_busy,
    output logic              underflow
);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(PKT_BYTES);

    typedef struct packed {
        logic [1:0]             full;
        bank_e                  wsel;
        bank_e                  rsel;
        logic [CNT_W-1:0]       wcnt;
        logic [CNT_W-1:0]       rptr;
        logic [1:0][CNT_W-1:0]  cnt;
        logic [DATA_W-1:0]      rdata;
        logic                   undf;
    } st_t;

    localparam st_t ST_RESET = '{
        full: 2'b00, wsel: BANK_A, rsel: BANK_A,
        wcnt: '0, rptr: '0, cnt: '0, rdata: '0, undf: 1'b0
    };

    st_t st_d, st_q;
    logic accept;
    logic rd_avail;

    always_comb begin
        st_d     = st_q;
        accept   = wr_valid && !st_q.full[st_q.wsel] && (st_q.wcnt < MAX_CNT);
        rd_avail = st_q.full[st_q.rsel] && (st_q.rptr < st_q.cnt[st_q.rsel]);

        // write side
        if (accept) begin
            st_d.wcnt = st_q.wcnt + 1'b1;
        end
        if (pkt_bad) begin
            st_d.wcnt = '0;
        end else if (pkt_good && !st_q.full[st_q.wsel]) begin
            st_d.full[st_q.wsel] = 1'b1;
            st_d.cnt[st_q.wsel]  = st_q.wcnt + CNT_W'(accept);
            st_d.wcnt            = '0;
            st_d.wsel            = other_bank(st_q.wsel);
        end

        // read side
        if (rd_strobe) begin
            if (rd_avail) begin
                st_d.rdata = mem_rdata;
                st_d.rptr  = st_q.rptr + 1'b1;
            end else begin
                st_d.rdata = '0;
                st_d.undf  = 1'b1;
            end
        end
        if (rd_done && st_q.full[st_q.rsel]) begin
            st_d.full[st_q.rsel] = 1'b0;
            st_d.rptr            = '0;
            st_d.rsel            = other_bank(st_q.rsel);
        end

        if (clr) begin
            st_d = ST_RESET;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we    = accept && !clr;
    assign mem_wbank = st_q.wsel;
    assign mem_waddr = st_q.wcnt[ADDR_W-1:0];
    assign mem_rbank = st_q.rsel;
    assign mem_raddr = st_q.rptr[ADDR_W-1:0];

    assign rd_data   = st_q.rdata;
    assign rx_size   = st_q.full[st_q.rsel] ? st_q.cnt[st_q.rsel] : '0;
    assign dma_req   = rd_avail;
    assign nak_busy  = &st_q.full;
    assign underflow = st_q.undf;
endmodule

// File: rtl/usb_rx_pingpong.sv
module usb_rx_pingpong #(
    parameter int DATA_W    = 8,
    parameter int PKT_BYTES = 64,
    localparam int ADDR_W   = $clog2(PKT_BYTES),
    localparam int CNT_W    = $clog2(PKT_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pkt_good,
    input  logic              pkt_bad,
    input  logic              rd_strobe,
    input  logic              rd_done,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  rx_size,
    output logic              dma_req,
    output logic              nak_busy,
    output logic              underflow
);
    logic              mem_we;
    logic              mem_wbank;
    logic [ADDR_W-1:0] mem_waddr;
    logic              mem_rbank;
    logic [ADDR_W-1:0] mem_raddr;
    logic [DATA_W-1:0] mem_rdata;

    rxb_bank_mem #(.DATA_W(DATA_W), .PKT_BYTES(PKT_BYTES)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .wbank (mem_wbank),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .rbank (mem_rbank),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    rxb_ctrl #(.DATA_W(DATA_W), .PKT_BYTES(PKT_BYTES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .wr_valid  (wr_valid),
        .pkt_good  (pkt_good),
        .pkt_bad   (pkt_bad),
        .rd_strobe (rd_strobe),
        .rd_done   (rd_done),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_wbank (mem_wbank),
        .mem_waddr (mem_waddr),
        .mem_rbank (mem_rbank),
        .mem_raddr (mem_raddr),
        .rd_data   (rd_data),
        .rx_size   (rx_size),
        .dma_req   (dma_req),
        .nak_busy  (nak_busy),
        .underflow (underflow)
    );
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
    parameter int DATA_W    = 8,
    parameter int PKT_BYTES = 64,
    localparam int CNT_W    = $clog2(PKT_BYTES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              pkt_good,
    input logic              pkt_bad,
    input logic              rd_strobe,
    input logic              rd_done,
    input logic [DATA_W-1:0] rd_data,
    input logic [CNT_W-1:0]  rx_size,
    input logic              dma_req,
    input logic              nak_busy,
    input logic              underflow
);
    AST_IN_ONE_MARKER: assume property (@(posedge clk) disable iff (!rst_n)
        !(pkt_good && pkt_bad));

    AST_SIZE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_size <= CNT_W'(PKT_BYTES)); // R2

    AST_SIZE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_size != '0 && !rd_done && !clr) |=> $stable(rx_size)); // R3

    AST_DMA_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (rx_size != '0)); // R5

    AST_BUSY_HAS_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (nak_busy && !clr) |=> (rx_size == $past(rx_size) || $past(rd_done))); // R6

    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rx_size == '0 && !dma_req && !nak_busy && !underflow)); // R7

    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !dma_req && !clr) |=> (rd_data == '0 && underflow)); // R8

    AST_UNDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !clr) |=> underflow); // R8

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_strobe && !clr) |=> $stable(rd_data)); // R10
endmodule

bind usb_rx_pingpong rxb_checker #(.DATA_W(DATA_W), .PKT_BYTES(PKT_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .pkt_good  (pkt_good),
    .pkt_bad   (pkt_bad),
    .rd_strobe (rd_strobe),
    .rd_done   (rd_done),
    .rd_data   (rd_data),
    .rx_size   (rx_size),
    .dma_req   (dma_req),
    .nak_busy  (nak_busy),
    .underflow (underflow)
);

// File: tb/tb_usb_rx_pingpong.sv
`timescale 1ns/1ps
module tb_usb_rx_pingpong;
    localparam int DATA_W = 8;
    localparam int PKT    = 64;
    localparam int CNT_W  = $clog2(PKT + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 0, wr_valid = 0, pkt_good = 0, pkt_bad = 0, rd_strobe = 0, rd_done = 0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic [CNT_W-1:0]  rx_size;
    logic dma_req, nak_busy, underflow;

    int checks = 0;
    int errors = 0;
    logic [DATA_W-1:0] exp_q [$];
    string rd_tag = "R1";
    logic  rd_seen = 1'b0;
    logic [7:0] seed = 8'h11;

    always #4 clk = ~clk;

    usb_rx_pingpong #(.DATA_W(DATA_W), .PKT_BYTES(PKT)) dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_valid(wr_valid), .wr_data(wr_data),
        .pkt_good(pkt_good), .pkt_bad(pkt_bad), .rd_strobe(rd_strobe), .rd_done(rd_done),
        .rd_data(rd_data), .rx_size(rx_size), .dma_req(dma_req), .nak_busy(nak_busy),
        .underflow(underflow)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: compares each read result with the scoreboard queue
    always @(posedge clk) rd_seen <= rd_strobe;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                chk({rd_tag, " queue empty"}, 1, 0);
            end else begin
                chk({rd_tag, " rd_data"}, int'(rd_data), int'(exp_q.pop_front()));
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // driver: sends a packet and pushes the bytes that should be read back
    task automatic send_pkt(input int len, input bit good, input bit expect_kept);
        for (int i = 0; i < len; i++) begin
            seed = seed * 8'd5 + 8'd3;
            wr_valid = 1'b1;
            wr_data  = seed;
            if (good && expect_kept && i < PKT) exp_q.push_back(seed);
            tick();
        end
        wr_valid = 1'b0;
        pkt_good = good;
        pkt_bad  = !good;
        tick();
        pkt_good = 1'b0;
        pkt_bad  = 1'b0;
    endtask

    task automatic read_n(input int n);
        for (int i = 0; i < n; i++) begin
            rd_strobe = 1'b1;
            tick();
        end
        rd_strobe = 1'b0;
        tick();
    endtask

    task automatic release_bank();
        rd_done = 1'b1;
        tick();
        rd_done = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        chk("watchdog", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R7 reset rx_size", int'(rx_size), 0);
        chk("R5 reset dma_req", int'(dma_req), 0);
        chk("R6 reset nak_busy", int'(nak_busy), 0);
        chk("R8 reset underflow", int'(underflow), 0);
        chk("R10 reset rd_data", int'(rd_data), 0);

        // single packet
        send_pkt(5, 1'b1, 1'b1);
        chk("R2 size of 5-byte packet", int'(rx_size), 5);
        chk("R5 dma_req with data", int'(dma_req), 1);
        rd_tag = "R1";
        read_n(5);
        chk("R5 dma_req drained", int'(dma_req), 0);
        chk("R2 size held after drain", int'(rx_size), 5);
        release_bank();
        chk("R4 size after release", int'(rx_size), 0);

        // both banks full, third packet ignored
        send_pkt(3, 1'b1, 1'b1);
        send_pkt(4, 1'b1, 1'b1);
        chk("R3 first packet stays readable", int'(rx_size), 3);
        chk("R6 nak_busy both full", int'(nak_busy), 1);
        send_pkt(2, 1'b1, 1'b0);
        chk("R6 size unchanged when busy", int'(rx_size), 3);
        rd_tag = "R3";
        read_n(3);
        release_bank();
        chk("R4 second bank readable", int'(rx_size), 4);
        chk("R6 busy cleared", int'(nak_busy), 0);
        rd_tag = "R6";
        read_n(4);
        release_bank();
        chk("R4 empty after both released", int'(rx_size), 0);

        // bad packet discarded
        send_pkt(6, 1'b0, 1'b0);
        chk("R9 bad packet leaves no size", int'(rx_size), 0);
        send_pkt(2, 1'b1, 1'b1);
        chk("R9 following good packet size", int'(rx_size), 2);
        rd_tag = "R9";
        read_n(2);
        release_bank();

        // oversize packet
        send_pkt(PKT + 6, 1'b1, 1'b1);
        chk("R2 oversize count saturates", int'(rx_size), PKT);
        rd_tag = "R2";
        read_n(PKT);
        release_bank();

        // partial read then release; pointer restarts
        send_pkt(5, 1'b1, 1'b1);
        rd_tag = "R4";
        read_n(2);
        release_bank();
        void'(exp_q.pop_front()); void'(exp_q.pop_front()); void'(exp_q.pop_front());
        send_pkt(3, 1'b1, 1'b1);
        read_n(3);
        release_bank();

        // release with nothing readable is ignored
        release_bank();
        send_pkt(4, 1'b1, 1'b1);
        chk("R4 idle release ignored", int'(rx_size), 4);
        read_n(4);
        release_bank();

        // underflow
        exp_q.push_back(8'h00);
        rd_tag = "R8";
        read_n(1);
        chk("R8 underflow set", int'(underflow), 1);
        repeat (3) tick();
        chk("R8 underflow sticky", int'(underflow), 1);

        // clear with both banks full
        send_pkt(3, 1'b1, 1'b0);
        send_pkt(3, 1'b1, 1'b0);
        chk("R6 busy before clear", int'(nak_busy), 1);
        clr = 1'b1;
        tick();
        clr = 1'b0;
        chk("R7 clear size", int'(rx_size), 0);
        chk("R7 clear busy", int'(nak_busy), 0);
        chk("R7 clear underflow", int'(underflow), 0);
        chk("R7 clear dma_req", int'(dma_req), 0);
        send_pkt(2, 1'b1, 1'b1);
        chk("R7 packet after clear", int'(rx_size), 2);
        rd_tag = "R7";
        read_n(2);
        release_bank();
        chk("R1 scoreboard empty", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule